// File: doc/BRIEF.md
# One's-Complement Adder/Subtractor with End-Around Carry

This block adds or subtracts two signed numbers held in one's-complement form. To subtract, it inverts every bit of the second operand and adds the result to the first operand. Any carry out of the top bit is folded back into the bottom bit. The two steps are done in a single combinational pass: the raw sum plus its own carry. The end-around addition can never carry again, so one fold is always enough.

When the fold happens, the result is a positive value in plain binary. When no carry leaves the top bit, the result is negative and is already in one's-complement form. Zero has two encodings, all zeros and all ones. The block accepts either encoding as an operand and may produce either one as a result.

Operands come with a valid strobe. The result, a negative indicator and an overflow flag are registered and appear one clock later with their own valid strobe. The outputs keep their values until the next strobed operation.

Top module: `ones_comp_subtractor`

## Requirements
- R1: With `subMode`=1, the value of `result` equals the value of `minuend` minus the value of `subtrahend` whenever the true difference lies in the range ±(2^(WIDTH-1)−1). A value is read as follows: top bit 0 means plain binary; top bit 1 means minus the bitwise inverse.
- R2: When the raw sum carries out of the top bit, the carry is added into the bit-0 position. At WIDTH=8, 5 − 1 yields exactly 8'h04.
- R3: When the raw sum has no carry out, it is passed unchanged as a negative one's-complement value. At WIDTH=8, 5 − 6 yields exactly 8'hFE (−1).
- R4: With `subMode`=0, the second operand enters the adder uninverted, the same end-around rule applies, and `result` carries the value of the sum.
- R5: Both zero encodings (all zeros and all ones) act as zero when used as operands. A zero true result may appear in either encoding.
- R6: `negative` equals the top bit of `result`. It is therefore 1 for every nonzero negative result and 0 for every nonzero positive result.
- R7: `overflow` is 1 exactly when the two adder operands share a sign bit and the sign bit of the folded result differs from it. This happens when the true result falls outside ±(2^(WIDTH-1)−1). Operands of opposite sign never raise it.
- R8: `outValid` rises on the clock edge after the edge that samples `inValid`=1, and falls after an edge that samples `inValid`=0. While no operation is strobed, `result`, `negative` and `overflow` hold their values.
- R9: While `rstN` is low, `outValid`, `result`, `negative` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and mode are valid this cycle |
| subMode | input | 1 | 1 = subtract, 0 = add |
| minuend | input | WIDTH | First operand, one's complement |
| subtrahend | input | WIDTH | Second operand, one's complement |
| outValid | output | 1 | Registered result is fresh |
| result | output | WIDTH | Folded sum or difference, one's complement |
| negative | output | 1 | Top bit of the result |
| overflow | output | 1 | Signed range exceeded |

## Verification
The assertions assume that `minuend`, `subtrahend` and `subMode` are free of unknown bits on every cycle that `inValid` is high. They also assume the inputs may change on any cycle, since the hold property watches only the registered outputs. The bench drives each operand pair from the negative clock edge, converting signed integers to one's-complement bit patterns. It includes the all-ones zero, the extreme values ±127 and sums that run past the range. Each expected value is compared by signed value rather than by bit pattern, so either zero encoding passes. Exact encodings are demanded only where a requirement states one.

// File: rtl/oc_sub_pkg.sv
package oc_sub_pkg;
  // Strobes sent from the control to the datapath each cycle.
  typedef struct packed {
    logic invertOperand;  // feed the bitwise inverse of the second operand
    logic capture;        // load the output registers this edge
  } ocStrobes_t;
endpackage

// File: rtl/oc_sub_control.sv
module oc_sub_control
  import oc_sub_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       subMode,
  output ocStrobes_t strobes,
  output logic       outValid
);
  always_comb begin
    strobes.invertOperand = subMode;
    strobes.capture       = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R8
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R8
endmodule

// File: rtl/oc_sub_datapath.sv
module oc_sub_datapath
  import oc_sub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ocStrobes_t       strobes,
  input  logic [WIDTH-1:0] minuend,
  input  logic [WIDTH-1:0] subtrahend,
  output logic [WIDTH-1:0] resultQ,
  output logic             negativeQ,
  output logic             overflowQ
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] opB;
  logic [WIDTH-1:0] rawSum;
  logic             carryOut;
  logic [WIDTH-1:0] folded;
  logic             ovf;

  // Selective complement of the second operand.
  assign opB = strobes.invertOperand ? ~subtrahend : subtrahend;

  // First pass: plain add with the carry out kept.
  assign {carryOut, rawSum} = {1'b0, minuend} + {1'b0, opB};

  // End-around carry: rawSum is at most all-ones minus one when carryOut
  // is set, so this second add never carries.
  assign folded = rawSum + {{MSB{1'b0}}, carryOut};

  assign ovf = (minuend[MSB] == opB[MSB]) && (folded[MSB] != minuend[MSB]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ   <= '0;
      negativeQ <= 1'b0;
      overflowQ <= 1'b0;
    end else if (strobes.capture) begin
      resultQ   <= folded;
      negativeQ <= folded[MSB];
      overflowQ <= ovf;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(resultQ) && $stable(overflowQ));  // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && (minuend[MSB] != opB[MSB])) |=> !overflowQ);  // R7
  AST_SELF_DIFF_NEG_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.invertOperand && (minuend == subtrahend))
      |=> (resultQ == {WIDTH{1'b1}}));  // R5
  AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(negativeQ) |-> resultQ[MSB]);  // R6
endmodule

// File: rtl/ones_comp_subtractor.sv
module ones_comp_subtractor
  import oc_sub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             subMode,
  input  logic [WIDTH-1:0] minuend,
  input  logic [WIDTH-1:0] subtrahend,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             negative,
  output logic             overflow
);
  ocStrobes_t strobes;

  oc_sub_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .subMode  (subMode),
    .strobes  (strobes),
    .outValid (outValid)
  );

  oc_sub_datapath #(.WIDTH(WIDTH)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .minuend    (minuend),
    .subtrahend (subtrahend),
    .resultQ    (result),
    .negativeQ  (negative),
    .overflowQ  (overflow)
  );
endmodule

// File: tb/ones_comp_subtractor_test.sv
module ones_comp_subtractor_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         subMode = 1'b0;
  logic [W-1:0] minuend = '0;
  logic [W-1:0] subtrahend = '0;
  logic         outValid;
  logic [W-1:0] result;
  logic         negative;
  logic         overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int       expVal;
    bit       expOvf;
    bit       exact;
    logic [W-1:0] expBits;
    string    tag;
  } item_t;

  item_t sb[$];

  ones_comp_subtractor #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .subMode(subMode),
    .minuend(minuend), .subtrahend(subtrahend), .outValid(outValid),
    .result(result), .negative(negative), .overflow(overflow)
  );

  always #4 clk = ~clk;  // 125 MHz

  function automatic int toVal(logic [W-1:0] v);
    logic [W-1:0] inv;
    inv = ~v;
    return v[W-1] ? -int'(inv) : int'(v);
  endfunction

  function automatic logic [W-1:0] enc(int x);
    logic [W-1:0] mag;
    mag = (x < 0) ? W'(-x) : W'(x);
    return (x < 0) ? ~mag : mag;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one operation and pushes its expectation.
  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, bit sub, string tag,
                       bit exact = 1'b0, logic [W-1:0] bits = '0);
    item_t it;
    int trueVal;
    int lim;
    lim = (1 << (W-1)) - 1;
    trueVal = sub ? (toVal(a) - toVal(b)) : (toVal(a) + toVal(b));
    it.expVal  = trueVal;
    it.expOvf  = (trueVal > lim) || (trueVal < -lim);
    it.exact   = exact;
    it.expBits = bits;
    it.tag     = tag;
    sb.push_back(it);
    inValid    = 1'b1;
    subMode    = sub;
    minuend    = a;
    subtrahend = b;
    @(negedge clk);
    inValid    = 1'b0;
  endtask

  // Monitor: pops an expectation for each fresh output.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8", "unexpected outValid", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(overflow == it.expOvf, it.tag, "overflow (R7)",
                int'(overflow), int'(it.expOvf));
          if (!it.expOvf) begin
            check(toVal(result) == it.expVal, it.tag, "value",
                  toVal(result), it.expVal);
            if (it.expVal != 0)
              check(negative == (it.expVal < 0), it.tag, "negative (R6)",
                    int'(negative), int'(it.expVal < 0));
            else
              check(negative == result[W-1], it.tag, "zero negative (R6)",
                    int'(negative), int'(result[W-1]));
          end
          if (it.exact)
            check(result == it.expBits, it.tag, "exact bits",
                  int'(result), int'(it.expBits));
        end
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      check(1'b0, "WDOG", "watchdog expired", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && result == '0 && negative == 1'b0 && overflow == 1'b0,
          "R9", "reset outputs", int'(result), 0);
    rstN = 1'b1;
    @(negedge clk);

    drive(enc(5), enc(1), 1'b1, "R2", 1'b1, 8'h04);
    drive(enc(5), enc(6), 1'b1, "R3", 1'b1, 8'hFE);
    drive(enc(50), enc(20), 1'b1, "R1");
    drive(enc(-30), enc(40), 1'b1, "R1");
    drive(enc(20), enc(-30), 1'b1, "R1");
    drive(enc(0), enc(0), 1'b1, "R1");
    drive(enc(127), enc(127), 1'b1, "R1");
    drive(enc(7), enc(9), 1'b0, "R4");
    drive(enc(-10), enc(4), 1'b0, "R4");
    drive(enc(60), enc(-60), 1'b0, "R4");
    drive(8'hFF, enc(5), 1'b1, "R5");
    drive(enc(12), 8'hFF, 1'b1, "R5");
    drive(8'hFF, 8'hFF, 1'b0, "R5");
    drive(enc(-127), enc(0), 1'b1, "R7");
    drive(enc(100), enc(-100), 1'b1, "R7");
    drive(enc(100), enc(100), 1'b0, "R7");
    drive(enc(-100), enc(-100), 1'b0, "R7");
    drive(enc(-100), enc(100), 1'b1, "R7");

    @(negedge clk);
    held = result;
    subMode = 1'b0; minuend = enc(33); subtrahend = enc(44);
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R8", "outValid idle", int'(outValid), 0);
    check(result == held, "R8", "result held", int'(result), int'(held));
    check(sb.size() == 0, "R8", "pending results", sb.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule